// File: doc/BRIEF.md
# Bus Master Address Tenure Controller

This block runs the master side of one address tenure on a shared bus where the address and data phases are split. A local client asks for a transfer by pulsing a request with an address and a set of transfer attributes. The controller stores them and asks the arbiter for the bus. Once the grant arrives, it drives the address and attributes and issues a one-cycle, active-low transfer-start strobe. It then keeps the address phase open for as long as the acknowledge takes to arrive.

The acknowledge input closes the address phase. In the cycle after a fresh acknowledge, the controller releases its address, attribute and strobe drivers and samples the shared, active-low retry line. If retry is low, the controller raises a one-cycle retried pulse and asks for the bus again, then reissues the same address and attributes. If retry is high, it raises a one-cycle done pulse and goes back to idle. Every bus-side signal is active low. Each driven bus group has its own output enable, so the surrounding logic or a bench can model tristate behaviour.

The states are IDLE, ARB, START, HOLD and SNOOP. The transitions are:
- IDLE to ARB: a local request is accepted.
- ARB to START: the grant is sampled low.
- START to HOLD: always, after one cycle.
- HOLD to SNOOP: a fresh acknowledge is seen.
- SNOOP to ARB: retry is sampled low.
- SNOOP to IDLE: retry is sampled high.

Top module: `addr_tenure_ctrl`

## Requirements
- R1: After reset, the outputs are in this state:
  - `bus_req_n_o`, `ts_n_o` are 1.
  - every output enable is 0.
  - `done_o`, `retried_o` are 0.
- R2: In IDLE, a high `xfer_req_i` stores `xfer_addr_i`/`xfer_attr_i`. From the next cycle, `bus_req_n_o` is 0 and stays 0 until `bus_grant_n_i` is sampled 0.
- R3: In the cycle after the grant is sampled, the controller enters START. In START:
  - `ts_n_o` is 0 for exactly one cycle.
  - `addr_oe_o`, `attr_oe_o` and `ts_oe_o` are 1.
- R4: From START until the cycle in which a fresh acknowledge is seen, for any number of cycles:
  - the address, attributes and their enables stay driven.
  - the driven values do not change.
- R5: In the cycle after a fresh acknowledge, `addr_oe_o`, `attr_oe_o` and `ts_oe_o` are 0.
- R6: In that cycle, a 0 on `artry_n_i` gives this result:
  - `retried_o` is 1 for one cycle.
  - `bus_req_n_o` is 0 from the next cycle.
  - the same stored address and attributes are driven on the next grant.
- R7: In that cycle, a 1 on `artry_n_i` gives this result:
  - `done_o` is 1 for one cycle.
  - the controller returns to IDLE.
- R8: A fresh acknowledge is a cycle with `aack_n_i` 0 whose previous cycle had `aack_n_i` 1. An acknowledge that is held low across consecutive cycles, or that is low during START, does not end the phase.
- R9: Changes on `xfer_addr_i` or `xfer_req_i` while a tenure is in progress have no effect on the driven address.
- R10: A low `bus_grant_n_i` while the controller is not requesting produces no transfer-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Local transfer request pulse |
| xfer_addr_i | input | AW | Local address |
| xfer_attr_i | input | TW | Local transfer attributes |
| bus_req_n_o | output | 1 | Bus request to arbiter, active low |
| bus_grant_n_i | input | 1 | Bus grant from arbiter, active low |
| addr_o | output | AW | Address bus value |
| addr_oe_o | output | 1 | Address bus drive enable |
| attr_o | output | TW | Attribute bus value |
| attr_oe_o | output | 1 | Attribute bus drive enable |
| ts_n_o | output | 1 | Transfer start, active low |
| ts_oe_o | output | 1 | Transfer start drive enable |
| aack_n_i | input | 1 | Address acknowledge, active low |
| artry_n_i | input | 1 | Shared address retry, active low |
| done_o | output | 1 | Address phase completed pulse |
| retried_o | output | 1 | Address phase retried pulse |

## Verification
The hardest case to reach from the ports is an acknowledge that is already low when HOLD begins. It must not count as fresh, so the phase stays open until the acknowledge goes high and then low again. The stimulus drives the acknowledge low during START and keeps it low for several cycles, then releases it and asserts it again. A behavioural reference model tracks the previous acknowledge level on its own and is compared with the outputs on every cycle. The stimulus also chains a retried tenure into a reissue, while the local address is changed in the middle of the tenure.

// File: rtl/atc_pkg.sv
package atc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARB   = 3'd1,
        ST_START = 3'd2,
        ST_HOLD  = 3'd3,
        ST_SNOOP = 3'd4
    } atc_state_e;
endpackage

// File: rtl/atc_ack_qual.sv
module atc_ack_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic ack_fresh_o
);
    logic ack_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_prev_q <= 1'b0;
        else        ack_prev_q <= ~ack_n_i;
    end

    assign ack_fresh_o = ~ack_n_i & ~ack_prev_q;

    // R8
    no_double_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fresh_o |=> !ack_fresh_o);
endmodule

// File: rtl/atc_hold_reg.sv
module atc_hold_reg #(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          drive_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] attr_i,
    output logic [AW-1:0] addr_o,
    output logic [TW-1:0] attr_o
);
    logic [AW-1:0] addr_q;
    logic [TW-1:0] attr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            attr_q <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            attr_q <= attr_i;
        end
    end

    assign addr_o = drive_i ? addr_q : '0;
    assign attr_o = drive_i ? attr_q : '0;

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && $past(drive_i)) |-> ($stable(addr_o) && $stable(attr_o)));

    // R9
    no_load_while_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i |-> !load_i);
endmodule

// File: rtl/atc_fsm.sv
module atc_fsm
    import atc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic grant_i,
    input  logic ack_fresh_i,
    input  logic retry_i,
    output logic load_o,
    output logic drive_o,
    output logic start_o,
    output logic bus_req_o,
    output logic done_o,
    output logic retried_o
);
    atc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (xfer_req_i)  state_d = ST_ARB;
            ST_ARB:   if (grant_i)     state_d = ST_START;
            ST_START:                  state_d = ST_HOLD;
            ST_HOLD:  if (ack_fresh_i) state_d = ST_SNOOP;
            ST_SNOOP: state_d = retry_i ? ST_ARB : ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o    = 1'b0;
        drive_o   = 1'b0;
        start_o   = 1'b0;
        bus_req_o = 1'b0;
        done_o    = 1'b0;
        retried_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_o = xfer_req_i;
            ST_ARB:   bus_req_o = 1'b1;
            ST_START: begin
                drive_o = 1'b1;
                start_o = 1'b1;
            end
            ST_HOLD:  drive_o = 1'b1;
            ST_SNOOP: begin
                done_o    = ~retry_i;
                retried_o = retry_i;
            end
            default: ;
        endcase
    end

    // R3
    ts_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!start_o && drive_o));

    // R5
    release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && !start_o && ack_fresh_i) |=> !drive_o);

    // R2
    req_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !grant_i) |=> bus_req_o);

    // R6
    retry_rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retried_o |=> bus_req_o);

    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && retried_o));

    // R10
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(bus_req_o));
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl #(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_req_i,
    input  logic [AW-1:0] xfer_addr_i,
    input  logic [TW-1:0] xfer_attr_i,
    output logic          bus_req_n_o,
    input  logic          bus_grant_n_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe_o,
    output logic [TW-1:0] attr_o,
    output logic          attr_oe_o,
    output logic          ts_n_o,
    output logic          ts_oe_o,
    input  logic          aack_n_i,
    input  logic          artry_n_i,
    output logic          done_o,
    output logic          retried_o
);
    logic ack_fresh, load, drive, start, bus_req;

    atc_ack_qual u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_i     (aack_n_i),
        .ack_fresh_o (ack_fresh)
    );

    atc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_req_i  (xfer_req_i),
        .grant_i     (~bus_grant_n_i),
        .ack_fresh_i (ack_fresh),
        .retry_i     (~artry_n_i),
        .load_o      (load),
        .drive_o     (drive),
        .start_o     (start),
        .bus_req_o   (bus_req),
        .done_o      (done_o),
        .retried_o   (retried_o)
    );

    atc_hold_reg #(.AW(AW), .TW(TW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .drive_i (drive),
        .addr_i  (xfer_addr_i),
        .attr_i  (xfer_attr_i),
        .addr_o  (addr_o),
        .attr_o  (attr_o)
    );

    assign bus_req_n_o = ~bus_req;
    assign addr_oe_o   = drive;
    assign attr_oe_o   = drive;
    assign ts_oe_o     = drive;
    assign ts_n_o      = ~start;
endmodule

// File: tb/test_addr_tenure_ctrl.sv
module test_addr_tenure_ctrl;
    localparam int AW = 32;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_req = 1'b0;
    logic [AW-1:0] xfer_addr = '0;
    logic [TW-1:0] xfer_attr = '0;
    logic bus_grant_n = 1'b1, aack_n = 1'b1, artry_n = 1'b1;
    logic bus_req_n, addr_oe, attr_oe, ts_n, ts_oe, done, retried;
    logic [AW-1:0] addr;
    logic [TW-1:0] attr;

    int checks = 0, errors = 0;
    int ph = 0;
    bit ack_was = 0;
    logic [AW-1:0] m_addr = '0;
    logic [TW-1:0] m_attr = '0;

    always #5 clk = ~clk;

    addr_tenure_ctrl #(.AW(AW), .TW(TW)) i_addr_tenure_ctrl (
        .clk(clk), .rst_n(rst_n), .xfer_req_i(xfer_req), .xfer_addr_i(xfer_addr),
        .xfer_attr_i(xfer_attr), .bus_req_n_o(bus_req_n), .bus_grant_n_i(bus_grant_n),
        .addr_o(addr), .addr_oe_o(addr_oe), .attr_o(attr), .attr_oe_o(attr_oe),
        .ts_n_o(ts_n), .ts_oe_o(ts_oe), .aack_n_i(aack_n), .artry_n_i(artry_n),
        .done_o(done), .retried_o(retried)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: ph 0 idle, 1 asking, 2 strobe, 3 holding, 4 sampling retry
    task automatic compare();
        bit drv;
        drv = (ph == 2) || (ph == 3);
        chk("R2 bus_req_n", bus_req_n, (ph == 1) ? 0 : 1);
        chk("R3 ts_n", ts_n, (ph == 2) ? 0 : 1);
        chk("R4/R5 addr_oe", addr_oe, drv);
        chk("R4/R5 attr_oe", attr_oe, drv);
        chk("R5 ts_oe", ts_oe, drv);
        if (drv) begin
            chk("R4/R9 addr", addr, m_addr);
            chk("R4 attr", attr, m_attr);
        end
        chk("R7 done", done, (ph == 4) && artry_n);
        chk("R6 retried", retried, (ph == 4) && !artry_n);
    endtask

    task automatic tick();
        bit fresh;
        #1 compare();
        @(posedge clk);
        fresh = !aack_n && !ack_was;
        ack_was = !aack_n;
        case (ph)
            0: if (xfer_req) begin m_addr = xfer_addr; m_attr = xfer_attr; ph = 1; end
            1: if (!bus_grant_n) ph = 2;
            2: ph = 3;
            3: if (fresh) ph = 4;
            default: ph = artry_n ? 0 : 1;
        endcase
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #12;
        // R1 reset state
        chk("R1 bus_req_n", bus_req_n, 1);
        chk("R1 ts_n", ts_n, 1);
        chk("R1 oe", {addr_oe, attr_oe, ts_oe}, 0);
        chk("R1 status", {done, retried}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 grant with no request
        bus_grant_n = 0; idle(3);
        chk("R10 no strobe", ts_n, 1);
        bus_grant_n = 1;

        // R2 R3 R7 quickest path
        xfer_req = 1; xfer_addr = 32'hA000_1234; xfer_attr = 5'h15; tick();
        xfer_req = 0; idle(2);
        bus_grant_n = 0; tick(); bus_grant_n = 1;
        tick();                      // START
        aack_n = 0; tick();          // fresh ack in HOLD
        aack_n = 1; artry_n = 1; tick();  // SNOOP, done
        idle(2);

        // R4 R6 R9 long hold, retry, reissue
        xfer_req = 1; xfer_addr = 32'h0BAD_F00D; xfer_attr = 5'h0A; tick();
        xfer_req = 0; bus_grant_n = 0; tick(); bus_grant_n = 1;
        xfer_addr = 32'h5555_5555; xfer_req = 1;
        idle(7); xfer_req = 0;
        chk("R9 address kept", addr, 32'h0BAD_F00D);
        aack_n = 0; tick();
        aack_n = 1; artry_n = 0; tick();   // retried
        artry_n = 1; idle(1);
        chk("R6 re-request", bus_req_n, 0);
        bus_grant_n = 0; tick(); bus_grant_n = 1;
        chk("R6 reissued address", addr, 32'h0BAD_F00D);
        idle(2);
        aack_n = 0; tick(); aack_n = 1; tick(); idle(1);

        // R8 ack low during START and held
        xfer_req = 1; xfer_addr = 32'h1357_9BDF; xfer_attr = 5'h03; tick();
        xfer_req = 0; bus_grant_n = 0; tick(); bus_grant_n = 1;
        aack_n = 0; tick();          // START with ack low
        idle(3);
        chk("R8 still held", addr_oe, 1);
        aack_n = 1; idle(2);
        aack_n = 0; tick(); aack_n = 1;
        artry_n = 1; tick();
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule